// File: doc/BRIEF.md
# Flash Read Prefetch Buffer Controller

This block sits between a 32-bit instruction-fetch port and a flash array whose read port is 128 bits wide. One flash access returns one 16-byte line. Fetched lines are held in two line buffers. Each buffer has a line tag and a valid bit. A request whose line is already buffered is answered on the next cycle without touching the flash. A request to any other line starts a demand fetch. The requested bytes are returned as soon as the line arrives. The controller then fetches the following line into the other buffer while the processor keeps reading from the current one. When the processor moves into that prefetched line, the line after it is fetched in turn.

The flash latency is set by a wait-state input: every flash access keeps the read strobe asserted for `wait_states + 1` cycles, and the value is latched when the access starts. Byte, halfword and word reads are supported. Only the low `FLASH_AW` address bits are decoded, so the flash image repeats across the whole address window. A flush input invalidates both buffers, so that the next reads fetch fresh contents.

The controller has three states:
- IDLE: the flash is not being read.
- PREFETCH: the next line is being read into the spare buffer, and the processor port stays open.
- DEMAND: a missed line is being read, and the processor port is held off.

The transitions are:
- IDLE to DEMAND: a missed request.
- IDLE to PREFETCH: a hit whose successor line is not buffered.
- PREFETCH to IDLE: the prefetch completes, or a flush arrives.
- PREFETCH to DEMAND: a missed request, which abandons the prefetch.
- DEMAND to PREFETCH: the fetch completes and the successor line is not held.
- DEMAND to IDLE: the fetch completes and the successor line is already held, or a flush arrived.

Top module: `fpb_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `fl_rd` are 0.
- R2: A request to a line held in neither buffer produces `rsp_valid` on the (ws+2)-th rising edge after its acceptance edge, where ws is `wait_states`.
- R3: A request to a line held in a valid buffer produces `rsp_valid` on the first rising edge after its acceptance edge.
- R4: Once a demand fetch of line L completes, line L+1 is fetched into the other buffer. A request to L+1 accepted ws+2 or more cycles later is a hit.
- R5: A hit on a line whose successor is not buffered prefetches that successor into the other buffer, replacing the line held there. After a hit on L+1, line L+2 hits and line L misses.
- R6: A miss accepted while a prefetch is running abandons the prefetch, and it is answered with the R2 latency.
- R7: `req_size` selects the access width: 0 is a byte, 1 is a halfword and 2 is a word. The data is taken little-endian from the line, at byte `addr[3:0]`, halfword `addr[3:1]` or word `addr[3:2]`, and is right-justified and zero-extended on `rsp_data`.
- R8: Address bits at and above `FLASH_AW` are ignored. Two addresses that differ only there return the same data.
- R9: A pulse on `flush` invalidates both buffers, so the next read of a previously buffered line is a miss.
- R10: A buffered line keeps hitting after any number of idle cycles between requests.
- R11: `req_ready` is 0 while a demand fetch is in progress.
- R12: The line after the last flash line is line 0. After a demand fetch of the last line, a read at address 0 hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate both line buffers |
| wait_states | input | WS_W | Flash wait-state count, latched when each access starts |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted when both valid and ready are high |
| req_addr | input | ADDR_W | Byte address of the read |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| rsp_valid | output | 1 | Read data valid, one cycle per request |
| rsp_data | output | 32 | Right-justified read data |
| fl_rd | output | 1 | Flash read strobe, held for the whole access |
| fl_line | output | FLASH_AW-4 | Line index being read from flash |
| fl_data | input | 128 | Flash line data, sampled in the last cycle of the access |

## Verification
A linear word walk across every line, with short idle gaps at each line change, is repeated for each wait-state value. It separates the first demand latency from buffer hits, and it shows that each line was fetched ahead of use. An exhaustive sweep over every byte, halfword and word address is run once with the upper address bits clear and once with them set. It separates lane and alignment errors from address-folding errors, whatever mix of hits and misses the sweep produces. Targeted jumps then isolate the cases that a plain walk cannot reach:
- a miss during a prefetch;
- a flush of a held line;
- the wrap from the last line to line 0;
- the replacement of an old line by a chained prefetch.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
    localparam int LINE_BYTES = 16;
    localparam int LINE_BITS  = LINE_BYTES * 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PREF   = 2'd1,
        ST_DEMAND = 2'd2
    } fpb_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/fpb_line_store.sv
module fpb_line_store
    import fpb_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          inv_en,
    input  logic                          inv_idx,
    input  logic                          wr_en,
    input  logic                          wr_idx,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [LINE_BITS-1:0]          wr_data,
    input  logic [TAG_W-1:0]              look_tag,
    output logic [1:0]                    hit_vec,
    output logic [1:0]                    valid_o,
    output logic [1:0][TAG_W-1:0]         tag_o,
    output logic [1:0][LINE_BITS-1:0]     data_o
);
    for (genvar g = 0; g < 2; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_o[g] <= 1'b0;
            end else if (flush) begin
                valid_o[g] <= 1'b0;
            end else if (wr_en && (wr_idx == 1'(g))) begin
                valid_o[g] <= 1'b1;
            end else if (inv_en && (inv_idx == 1'(g))) begin
                valid_o[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == 1'(g))) begin
                tag_o[g]  <= wr_tag;
                data_o[g] <= wr_data;
            end
        end

        assign hit_vec[g] = valid_o[g] && (tag_o[g] == look_tag);
    end

    // A line is never held twice, so at most one entry can hit (R3).
    assert_unique_tags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o[0] && valid_o[1] && (tag_o[0] == tag_o[1])));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> (valid_o == 2'b00));
endmodule

// File: rtl/fpb_wait_timer.sv
module fpb_wait_timer #(
    parameter int WS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WS_W-1:0] load,
    output logic            done
);
    logic [WS_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/fpb_lane_pick.sv
module fpb_lane_pick
    import fpb_pkg::*;
(
    input  logic [LINE_BITS-1:0] line,
    input  logic [3:0]           off,
    input  logic [1:0]           size,
    output logic [31:0]          data
);
    always_comb begin
        unique case (size)
            SZ_BYTE: data = {24'b0, line[{off, 3'b000} +: 8]};
            SZ_HALF: data = {16'b0, line[{off[3:1], 4'b0000} +: 16]};
            default: data = line[{off[3:2], 5'b00000} +: 32];
        endcase
    end
endmodule

// File: rtl/fpb_ctrl.sv
module fpb_ctrl
    import fpb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int FLASH_AW = 17,
    parameter int WS_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [WS_W-1:0]        wait_states,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [1:0]             req_size,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_data,
    output logic                   fl_rd,
    output logic [FLASH_AW-5:0]    fl_line,
    input  logic [LINE_BITS-1:0]   fl_data
);
    localparam int LINE_AW = FLASH_AW - 4;

    fpb_state_e         state_q, state_d;
    logic [LINE_AW-1:0] line_q, line_d;
    logic               tgt_q, tgt_d;
    logic               cur_q, cur_d;
    logic [3:0]         off_q;
    logic [1:0]         size_q;

    logic               acc, hit_any, hit_idx, done, tmr_done, tmr_start;
    logic               wr_en, inv_en, inv_idx;
    logic               other_has_next, spare_has_next;
    logic [1:0]         hit_vec, hit_ok, valid_v;
    logic [1:0][LINE_AW-1:0]   tag_v;
    logic [1:0][LINE_BITS-1:0] data_v;
    logic [LINE_AW-1:0] req_line, nxt_req, nxt_fl;
    logic [LINE_BITS-1:0] pick_line;
    logic [3:0]         pick_off;
    logic [1:0]         pick_size;
    logic [31:0]        pick_data;
    logic               unused_addr_bits;

    assign unused_addr_bits = ^req_addr[ADDR_W-1:FLASH_AW];
    assign req_line  = req_addr[FLASH_AW-1:4];
    assign nxt_req   = req_line + 1'b1;
    assign nxt_fl    = line_q + 1'b1;
    assign req_ready = (state_q != ST_DEMAND);
    assign acc       = req_valid && req_ready;
    assign hit_ok    = hit_vec & {2{~flush}};
    assign hit_any   = |hit_ok;
    assign hit_idx   = hit_ok[1];
    assign done      = tmr_done && (state_q != ST_IDLE);
    assign fl_rd     = (state_q != ST_IDLE);
    assign fl_line   = line_q;

    assign other_has_next = valid_v[~hit_idx] && (tag_v[~hit_idx] == nxt_req);
    assign spare_has_next = valid_v[~tgt_q] && (tag_v[~tgt_q] == nxt_fl);

    fpb_line_store #(.TAG_W(LINE_AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .inv_en   (inv_en),
        .inv_idx  (inv_idx),
        .wr_en    (wr_en),
        .wr_idx   (tgt_q),
        .wr_tag   (line_q),
        .wr_data  (fl_data),
        .look_tag (req_line),
        .hit_vec  (hit_vec),
        .valid_o  (valid_v),
        .tag_o    (tag_v),
        .data_o   (data_v)
    );

    fpb_wait_timer #(.WS_W(WS_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .load  (wait_states),
        .done  (tmr_done)
    );

    assign pick_line = (state_q == ST_DEMAND) ? fl_data : data_v[hit_idx];
    assign pick_off  = (state_q == ST_DEMAND) ? off_q   : req_addr[3:0];
    assign pick_size = (state_q == ST_DEMAND) ? size_q  : req_size;

    fpb_lane_pick u_lane (
        .line (pick_line),
        .off  (pick_off),
        .size (pick_size),
        .data (pick_data)
    );

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            tgt_q   <= 1'b0;
            cur_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            tgt_q   <= tgt_d;
            cur_q   <= cur_d;
        end
    end

    // Next-state and control
    always_comb begin
        state_d   = state_q;
        line_d    = line_q;
        tgt_d     = tgt_q;
        cur_d     = cur_q;
        tmr_start = 1'b0;
        wr_en     = 1'b0;
        inv_en    = 1'b0;
        inv_idx   = tgt_q;
        unique case (state_q)
            ST_IDLE, ST_PREF: begin
                if (acc && !hit_any) begin
                    state_d   = ST_DEMAND;
                    line_d    = req_line;
                    tgt_d     = ~cur_q;
                    tmr_start = 1'b1;
                    inv_en    = 1'b1;
                    inv_idx   = ~cur_q;
                end else begin
                    if (state_q == ST_PREF) begin
                        if (flush) begin
                            state_d = ST_IDLE;
                        end else if (done) begin
                            wr_en   = 1'b1;
                            state_d = ST_IDLE;
                        end
                    end
                    if (acc && hit_any) begin
                        cur_d = hit_idx;
                        if ((state_q == ST_IDLE) && !other_has_next) begin
                            state_d   = ST_PREF;
                            line_d    = nxt_req;
                            tgt_d     = ~hit_idx;
                            tmr_start = 1'b1;
                            inv_en    = 1'b1;
                            inv_idx   = ~hit_idx;
                        end
                    end
                end
            end
            ST_DEMAND: begin
                if (done) begin
                    wr_en = 1'b1;
                    cur_d = tgt_q;
                    if (!flush && !spare_has_next) begin
                        state_d   = ST_PREF;
                        line_d    = nxt_fl;
                        tgt_d     = ~tgt_q;
                        tmr_start = 1'b1;
                        inv_en    = 1'b1;
                        inv_idx   = ~tgt_q;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            off_q     <= '0;
            size_q    <= '0;
        end else begin
            rsp_valid <= (acc && hit_any) || ((state_q == ST_DEMAND) && done);
            if ((acc && hit_any) || ((state_q == ST_DEMAND) && done)) begin
                rsp_data <= pick_data;
            end
            if (acc) begin
                off_q  <= req_addr[3:0];
                size_q <= req_size;
            end
        end
    end

    assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && hit_any) |=> rsp_valid);

    assert_miss_not_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !hit_any) |=> !rsp_valid);

    assert_ready_low_after_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !hit_any) |=> !req_ready);

    assert_line_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_rd && $past(fl_rd) && !$past(tmr_start)) |-> $stable(fl_line));
endmodule

// File: tb/fpb_ctrl_bench.sv
module fpb_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W   = 16;
    localparam int FLASH_AW = 8;
    localparam int WS_W     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [WS_W-1:0] wait_states = '0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0] req_size = 2'd2;
    logic rsp_valid;
    logic [31:0] rsp_data;
    logic fl_rd;
    logic [FLASH_AW-5:0] fl_line;
    logic [127:0] fl_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpb_ctrl #(.ADDR_W(ADDR_W), .FLASH_AW(FLASH_AW), .WS_W(WS_W)) u_fpb_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wait_states(wait_states),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fl_rd(fl_rd), .fl_line(fl_line), .fl_data(fl_data)
    );

    function automatic logic [7:0] fbyte(input int a);
        return 8'((a * 37 + 11) ^ (a >> 5));
    endfunction

    always_comb begin
        for (int i = 0; i < 16; i++) begin
            fl_data[i*8 +: 8] = fbyte(int'(fl_line) * 16 + i);
        end
    end

    function automatic logic [31:0] expect_data(input int addr, input int sz);
        int a;
        int b;
        a = addr % (1 << FLASH_AW);
        if (sz == 0) return {24'b0, fbyte(a)};
        if (sz == 1) begin
            b = a & ~1;
            return {16'b0, fbyte(b + 1), fbyte(b)};
        end
        b = a & ~3;
        return {fbyte(b + 3), fbyte(b + 2), fbyte(b + 1), fbyte(b)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, input int sz, output int lat,
                      output logic [31:0] d, output bit rdy1);
        while (!req_ready) @(negedge clk);
        req_addr  = ADDR_W'(a);
        req_size  = 2'(sz);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat  = 1;
        rdy1 = req_ready;
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        d = rsp_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int lat;
        int ws;
        logic [31:0] d;
        bit r1;
        idle(3);
        // R1: state during reset and just after it
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        check(fl_rd == 1'b0, "R1 fl_rd", int'(fl_rd), 0);
        rst_n = 1'b1;
        idle(2);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && fl_rd == 1'b0, "R1 after release",
              int'({req_ready, rsp_valid, fl_rd}), 4);

        for (int w = 0; w < 4; w++) begin
            ws = w;
            wait_states = WS_W'(w);
            idle(8);
            pulse_flush();
            // Linear word walk over all lines
            for (int L = 0; L < 16; L++) begin
                for (int k = 0; k < 4; k++) begin
                    rd(L * 16 + k * 4, 2, lat, d, r1);
                    check(d == expect_data(L * 16 + k * 4, 2), "R7 walk data", d,
                          expect_data(L * 16 + k * 4, 2));
                    if (L == 0 && k == 0) begin
                        check(lat == ws + 2, "R2 first miss latency", lat, ws + 2);
                        check(r1 == 1'b0, "R11 ready low in demand", int'(r1), 0);
                    end else if (k == 0 && L == 1) begin
                        check(lat == 1, "R4 prefetched line hit", lat, 1);
                    end else if (k == 0) begin
                        check(lat == 1, "R5 chained prefetch hit", lat, 1);
                    end else begin
                        check(lat == 1, "R3 same-line hit", lat, 1);
                    end
                end
                idle(ws + 2);
            end
            idle(20);
            rd(15 * 16 + 8, 2, lat, d, r1);
            check(lat == 1, "R10 hit after idle gap", lat, 1);

            // R12: wrap from the last line to line 0
            pulse_flush();
            rd(15 * 16, 2, lat, d, r1);
            check(lat == ws + 2, "R12 last line miss", lat, ws + 2);
            idle(ws + 2);
            rd(0, 2, lat, d, r1);
            check(lat == 1, "R12 wrap prefetch hit", lat, 1);
            check(d == expect_data(0, 2), "R12 wrap data", d, expect_data(0, 2));

            // R6: a miss during a prefetch
            idle(ws + 4);
            pulse_flush();
            rd(3 * 16, 2, lat, d, r1);
            rd(9 * 16 + 4, 2, lat, d, r1);
            check(lat == ws + 2, "R6 miss aborts prefetch", lat, ws + 2);
            check(d == expect_data(9 * 16 + 4, 2), "R6 data", d, expect_data(9 * 16 + 4, 2));

            // R9: flush of a held line
            idle(ws + 4);
            pulse_flush();
            rd(5 * 16, 2, lat, d, r1);
            rd(5 * 16 + 4, 2, lat, d, r1);
            check(lat == 1, "R9 hit before flush", lat, 1);
            idle(ws + 4);
            pulse_flush();
            rd(5 * 16 + 8, 2, lat, d, r1);
            check(lat == ws + 2, "R9 miss after flush", lat, ws + 2);

            // R5: a chained prefetch replaces the old line
            idle(ws + 4);
            pulse_flush();
            rd(2 * 16, 2, lat, d, r1);
            idle(ws + 2);
            rd(3 * 16, 2, lat, d, r1);
            check(lat == 1, "R5 L+1 hit", lat, 1);
            idle(ws + 2);
            rd(4 * 16, 2, lat, d, r1);
            check(lat == 1, "R5 L+2 hit", lat, 1);
            rd(2 * 16, 2, lat, d, r1);
            check(lat == ws + 2, "R5 old line replaced", lat, ws + 2);
        end

        // Exhaustive lane sweeps, then with the upper bits set
        wait_states = WS_W'(1);
        for (int sz = 0; sz < 3; sz++) begin
            for (int a = 0; a < 256; a += (1 << sz)) begin
                rd(a, sz, lat, d, r1);
                check(d == expect_data(a, sz), "R7 lane data", d, expect_data(a, sz));
            end
            for (int a = 0; a < 256; a += (1 << sz)) begin
                int hi;
                hi = ((a * 5 + 1) % 255) + 1;
                rd((hi << FLASH_AW) | a, sz, lat, d, r1);
                check(d == expect_data(a, sz), "R8 aliased address data", d,
                      expect_data(a, sz));
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule